// File: doc/BRIEF.md
# Sticky DMA Interrupt Status

This block holds the interrupt status bit of a DMA dispatcher and drives the level interrupt that follows it. Each descriptor carries its own interrupt masks: a completion mask bit, an early-termination mask bit and an error mask as wide as the error field. These masks are written into a small in-order buffer when the descriptor is committed. When the dispatcher reports that a descriptor has finished, the oldest masks are taken from the buffer and used to qualify that descriptor's events.

A qualifying event sets a sticky status bit. The interrupt output is high for as long as the bit is set. Software clears the bit by writing 1 to it through a single-bit CSR write port. Writing 0 does nothing. If a hardware set and a software clear arrive in the same cycle, the set wins.

The early-termination and error sources are only built when the block is configured for stream-to-memory transfers. In every other configuration, only completion can raise the interrupt. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `dma_irq_status`

## Requirements
- R1: While reset is held, `irq_o` is 0 and `mask_full_o` is 0.
- R2: A completion report (`done_i`=1) whose buffered completion mask is 1 sets the status. `irq_o` is 1 from the first clock edge after the report.
- R3: A completion report whose buffered masks all miss its events leaves `irq_o` at 0. Its masks are still consumed.
- R4: With stream-to-memory enabled, a report raises the interrupt through the error path only when (`done_err_i` AND the buffered error mask) is nonzero.
- R5: With stream-to-memory enabled, a report with `done_early_i`=1 and a buffered early-termination mask of 1 raises the interrupt.
- R6: Masks are buffered first-in first-out. Each report consumes the oldest entry.
- R7: Once set, `irq_o` stays 1 until a cycle with `csr_wr_i`=1 and `csr_clr_i`=1 and no new set. `irq_o` is 0 after that edge. A write with `csr_clr_i`=0 has no effect.
- R8: A set and a write-1-clear in the same cycle leave the status at 1.
- R9: A report that arrives while the mask buffer is empty sets nothing and consumes nothing.
- R10: `mask_full_o` is 1 exactly when DEPTH entries are held. A push while full and with no report in the same cycle is dropped.
- R11: With stream-to-memory disabled, error and early-termination events are ignored. Only the completion mask can set the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| desc_push_i | input | 1 | Commit one descriptor's masks into the buffer |
| desc_cmpl_mask_i | input | 1 | Completion interrupt mask of the committed descriptor |
| desc_err_mask_i | input | ERR_W | Error interrupt mask of the committed descriptor |
| desc_et_mask_i | input | 1 | Early-termination interrupt mask of the committed descriptor |
| mask_full_o | output | 1 | Buffer holds DEPTH entries |
| done_i | input | 1 | Dispatcher reports one finished descriptor |
| done_err_i | input | ERR_W | Error bits accumulated by the finished descriptor |
| done_early_i | input | 1 | Finished descriptor ended by early termination |
| csr_wr_i | input | 1 | CSR write strobe for the status bit |
| csr_clr_i | input | 1 | Written value of the status bit (1 clears) |
| irq_o | output | 1 | Active-high level interrupt |

## Verification
Directed cases try each event source on its own, with the matching mask set and with it cleared. An error vector that misses the error mask must be told apart from one that overlaps it. The same directed traffic drives a second instance built without stream-to-memory, so the error and early-termination paths can be seen switched off. Corner cases include a report against an empty buffer, a set coinciding with a clear, zero writes, and a full buffer drained in order with alternating masks, which exposes any reordering. A long seeded random run then mixes pushes, reports and writes against a bench model of the buffer and both status bits.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  typedef enum logic [1:0] {
    SRC_CMPL = 2'd0,
    SRC_ET   = 2'd1,
    SRC_ERR  = 2'd2
  } irq_src_e;

  localparam int unsigned NUM_SRC = 3;
endpackage

// File: rtl/dma_irq_rst_sync.sv
module dma_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dma_irq_mask_fifo.sv
module dma_irq_mask_fifo #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop_ok, push_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULLCNT);
  assign head_o  = mem_q[rd_ptr_q];

  always_comb begin
    pop_ok   = pop_i && !empty_o;
    push_ok  = push_i && (!full_o || pop_ok);
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) begin
      wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop_ok) begin
      rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    end
    if (push_ok && !pop_ok) begin
      cnt_d = cnt_q + 1'b1;
    end else if (pop_ok && !push_ok) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_q[wr_ptr_q] <= data_i;
    end
  end

  // R10: a push into a full buffer without a pop changes nothing
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> $stable(cnt_q));

  // R9: a pop on an empty buffer consumes nothing
  p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> empty_o);

  // R6: occupancy never exceeds the depth
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULLCNT);
endmodule

// File: rtl/dma_irq_event_qual.sv
module dma_irq_event_qual
  import dma_irq_pkg::*;
#(
  parameter int unsigned ERR_W         = 8,
  parameter bit          STREAM_TO_MEM = 1'b1
) (
  input  logic               done_i,
  input  logic               head_valid_i,
  input  logic               cmpl_mask_i,
  input  logic               et_mask_i,
  input  logic [ERR_W-1:0]   err_mask_i,
  input  logic [ERR_W-1:0]   err_i,
  input  logic               early_i,
  output logic [NUM_SRC-1:0] hit_o,
  output logic               any_o
);
  logic report;

  assign report = done_i && head_valid_i;

  always_comb begin
    hit_o[SRC_CMPL] = report && cmpl_mask_i;
  end

  generate
    if (STREAM_TO_MEM) begin : g_s2m
      always_comb begin
        hit_o[SRC_ET]  = report && early_i && et_mask_i;
        hit_o[SRC_ERR] = report && |(err_i & err_mask_i);
      end
    end else begin : g_no_s2m
      always_comb begin
        hit_o[SRC_ET]  = 1'b0;
        hit_o[SRC_ERR] = 1'b0;
      end
    end
  endgenerate

  assign any_o = |hit_o;
endmodule

// File: rtl/dma_irq_status_reg.sv
module dma_irq_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic status_o
);
  logic status_q, status_d;
  logic clr;

  always_comb begin
    clr      = wr_i && wdata_i;
    status_d = set_i || (status_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else begin
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

  // R8: a hardware set wins over a simultaneous clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> status_o);

  // R7: write-1 without a set clears
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i && !set_i) |=> !status_o);

  // R7: without set or write-1, the bit holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !(wr_i && wdata_i)) |=> $stable(status_o));
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int unsigned ERR_W         = 8,
  parameter int unsigned DEPTH         = 4,
  parameter bit          STREAM_TO_MEM = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_push_i,
  input  logic             desc_cmpl_mask_i,
  input  logic [ERR_W-1:0] desc_err_mask_i,
  input  logic             desc_et_mask_i,
  output logic             mask_full_o,
  input  logic             done_i,
  input  logic [ERR_W-1:0] done_err_i,
  input  logic             done_early_i,
  input  logic             csr_wr_i,
  input  logic             csr_clr_i,
  output logic             irq_o
);
  localparam int unsigned MW = ERR_W + 2;

  logic               rst_sync_n;
  logic [MW-1:0]      push_word;
  logic [MW-1:0]      head_word;
  logic               mask_empty;
  logic [NUM_SRC-1:0] hit;
  logic               set_any;
  logic               status;

  assign push_word = {desc_cmpl_mask_i, desc_et_mask_i, desc_err_mask_i};

  dma_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dma_irq_mask_fifo #(.W(MW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .push_i  (desc_push_i),
    .data_i  (push_word),
    .pop_i   (done_i),
    .head_o  (head_word),
    .empty_o (mask_empty),
    .full_o  (mask_full_o)
  );

  dma_irq_event_qual #(.ERR_W(ERR_W), .STREAM_TO_MEM(STREAM_TO_MEM)) u_qual (
    .done_i       (done_i),
    .head_valid_i (!mask_empty),
    .cmpl_mask_i  (head_word[MW-1]),
    .et_mask_i    (head_word[MW-2]),
    .err_mask_i   (head_word[ERR_W-1:0]),
    .err_i        (done_err_i),
    .early_i      (done_early_i),
    .hit_o        (hit),
    .any_o        (set_any)
  );

  dma_irq_status_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_i    (set_any),
    .wr_i     (csr_wr_i),
    .wdata_i  (csr_clr_i),
    .status_o (status)
  );

  assign irq_o = status;

  // R9: a report against an empty buffer cannot raise the interrupt
  p_empty_done_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_i && mask_empty && !irq_o) |=> !irq_o);

  // R3: with no report, a low interrupt stays low
  p_no_report_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!done_i && !irq_o) |=> !irq_o);
endmodule

// File: tb/dma_irq_status_tb.sv
module dma_irq_status_tb_top;
  localparam int ERR_W = 8;
  localparam int DEPTH = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             push, cm, etm, done, early, wr, clrb;
  logic [ERR_W-1:0] em, err;
  logic             full_s, full_m, irq_s, irq_m;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  logic             q_c [DEPTH];
  logic             q_t [DEPTH];
  logic [ERR_W-1:0] q_e [DEPTH];
  int               cnt = 0;
  logic             exp_s = 1'b0;
  logic             exp_m = 1'b0;

  always #5 clk = ~clk;

  dma_irq_status #(.ERR_W(ERR_W), .DEPTH(DEPTH), .STREAM_TO_MEM(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .desc_push_i(push), .desc_cmpl_mask_i(cm),
    .desc_err_mask_i(em), .desc_et_mask_i(etm), .mask_full_o(full_s),
    .done_i(done), .done_err_i(err), .done_early_i(early),
    .csr_wr_i(wr), .csr_clr_i(clrb), .irq_o(irq_s));

  dma_irq_status #(.ERR_W(ERR_W), .DEPTH(DEPTH), .STREAM_TO_MEM(1'b0)) dut_m2m_i (
    .clk(clk), .rst_n(rst_n), .desc_push_i(push), .desc_cmpl_mask_i(cm),
    .desc_err_mask_i(em), .desc_et_mask_i(etm), .mask_full_o(full_m),
    .done_i(done), .done_err_i(err), .done_early_i(early),
    .csr_wr_i(wr), .csr_clr_i(clrb), .irq_o(irq_m));

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic qual_s2m(input logic c, input logic t, input logic [ERR_W-1:0] m,
                                    input logic e, input logic [ERR_W-1:0] ev);
    return c | (e & t) | (|(ev & m));
  endfunction

  // drive one cycle from a negedge, update the model, check at the next negedge
  task automatic cyc(input logic p, input logic c, input logic [ERR_W-1:0] m, input logic t,
                     input logic d, input logic [ERR_W-1:0] ev, input logic e,
                     input logic w, input logic b, input string tag);
    logic pop, hs, hm, clr, pok;
    push = p; cm = c; em = m; etm = t; done = d; err = ev; early = e; wr = w; clrb = b;
    pop = d && (cnt > 0);
    hs  = pop && qual_s2m(q_c[0], q_t[0], q_e[0], e, ev);
    hm  = pop && q_c[0];
    clr = w && b;
    exp_s = hs | (exp_s & ~clr);
    exp_m = hm | (exp_m & ~clr);
    pok = p && ((cnt < DEPTH) || pop);
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        q_c[i] = q_c[i+1]; q_t[i] = q_t[i+1]; q_e[i] = q_e[i+1];
      end
      cnt--;
    end
    if (pok) begin
      q_c[cnt] = c; q_t[cnt] = t; q_e[cnt] = m;
      cnt++;
    end
    @(posedge clk);
    @(negedge clk);
    chk(irq_s, exp_s, tag, "irq (stream-to-memory)");
    chk(irq_m, exp_m, (tag == "R6") ? "R11" : tag, "irq (no stream-to-memory)");
    chk(full_s, cnt == DEPTH, "R10", "mask_full");
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, '0, 0, 0, '0, 0, 0, 0, tag);
  endtask

  task automatic clear_all();
    cyc(0, 0, '0, 0, 0, '0, 0, 1, 1, "R7");
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0;
    push = 0; cm = 0; em = '0; etm = 0; done = 0; err = '0; early = 0; wr = 0; clrb = 0;
    repeat (3) @(negedge clk);
    chk(irq_s, 1'b0, "R1", "irq in reset");
    chk(irq_m, 1'b0, "R1", "irq in reset");
    chk(full_s, 1'b0, "R1", "full in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: report with empty buffer
    cyc(0, 0, '0, 0, 1, 8'hFF, 1, 0, 0, "R9");
    idle("R9");
    // R2 then R7 hold, zero write, clear
    cyc(1, 1, '0, 0, 0, '0, 0, 0, 0, "R2");
    cyc(0, 0, '0, 0, 1, '0, 0, 0, 0, "R2");
    idle("R7");
    cyc(0, 0, '0, 0, 0, '0, 0, 1, 0, "R7");
    clear_all();
    // R3: all masks miss
    cyc(1, 0, '0, 0, 0, '0, 0, 0, 0, "R3");
    cyc(0, 0, '0, 0, 1, 8'hFF, 1, 0, 0, "R3");
    // R4: non-overlapping then overlapping error bits; R11 on second instance
    cyc(1, 0, 8'h10, 0, 0, '0, 0, 0, 0, "R4");
    cyc(0, 0, '0, 0, 1, 8'h01, 0, 0, 0, "R4");
    cyc(1, 0, 8'h10, 0, 0, '0, 0, 0, 0, "R4");
    cyc(0, 0, '0, 0, 1, 8'h30, 0, 0, 0, "R4");
    clear_all();
    // R5: early termination
    cyc(1, 0, '0, 1, 0, '0, 0, 0, 0, "R5");
    cyc(0, 0, '0, 0, 1, '0, 1, 0, 0, "R5");
    idle("R11");
    clear_all();
    // R8: set and clear in same cycle
    cyc(1, 1, '0, 0, 0, '0, 0, 0, 0, "R8");
    cyc(1, 1, '0, 0, 1, '0, 0, 0, 0, "R8");
    cyc(0, 0, '0, 0, 1, '0, 0, 1, 1, "R8");
    clear_all();
    // R10 fill beyond depth, then R6 drain order
    for (int k = 0; k < DEPTH + 1; k++) begin
      cyc(1, logic'(k % 2 == 0), '0, 0, 0, '0, 0, 0, 0, "R10");
    end
    for (int k = 0; k < DEPTH; k++) begin
      cyc(0, 0, '0, 0, 1, '0, 0, 0, 0, "R6");
      clear_all();
    end

    // seeded random mix
    for (int k = 0; k < 4000; k++) begin
      cyc(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 3) == 0),
          ERR_W'($urandom_range(0, 3) == 0 ? $urandom : 0), logic'($urandom_range(0, 3) == 0),
          logic'($urandom_range(0, 2) == 0), ERR_W'($urandom_range(0, 1) == 0 ? $urandom : 0),
          logic'($urandom_range(0, 3) == 0), logic'($urandom_range(0, 3) == 0),
          logic'($urandom_range(0, 1)), "R6");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule